// File: doc/BRIEF.md
# Paired-Page Associative Translation Buffer

This block is a fully associative address translation array. Every entry maps one pair of adjacent virtual pages to two physical frames: one frame for the even page of the pair, one for the odd page. Each entry carries a page mask, an address-space tag and a global flag. The mask takes VPN bits out of the tag compare so that large pages can be mapped. The global flag lets an entry match every address space.

Two search ports read the array in parallel. The translate port takes a VPN pair number, an address-space tag and an even/odd select bit. It returns a hit flag, the index of the matching entry and the frame number and flags of the selected page. The probe port takes a VPN and a tag and returns only the matching index, or all ones when nothing matches. Both ports are registered and produce their result one cycle after the request. An indexed write port loads one entry from a high word holding the VPN and tag, a mask word, and two low words, one for each page of the pair. A flush input empties the whole array in one cycle.

Segment decoding, fault generation, replacement choice and page-table walking are left to the surrounding logic.

Top module: `tlbp_array`

## Requirements
- R1: After reset, or in the cycle after `flush` is high, no entry matches on either port. When `flush` and `wr_en` are high in the same cycle, the flush wins and the write is dropped.
- R2: An entry matches a VPN only if the VPN and the stored VPN are equal in every bit position where the entry's mask word holds a 0. Bits where the mask holds a 1 are not compared.
- R3: An entry matches only if its stored tag equals the request tag or its global flag is set. The global flag is the AND of bit 0 of the two low words given at write time.
- R4: Each low word is packed as {frame number, cache attribute[5:3], dirty[2], valid[1], global[0]}. On a translate hit, `tr_odd`=0 returns the fields of the first low word and `tr_odd`=1 returns the fields of the second.
- R5: `pb_idx` is one bit wider than an entry index. On a match it holds the entry index with the top bit 0. With no match it holds all ones.
- R6: When several entries match, both ports report the lowest index.
- R7: A write with `wr_idx` greater than or equal to ENTRIES changes no entry.
- R8: A write to an index replaces that entry completely, so the VPN it held before no longer matches.
- R9: Port results appear one cycle after the request. A write becomes visible to requests made in the next cycle. A request made in the same cycle as a write sees the old contents.
- R10: On a translate miss, `tr_idx`, `tr_pfn`, `tr_cattr`, `tr_dirty`, `tr_valid` and `tr_global` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, empties the array |
| tr_vpn | input | VPN_W | Translate request VPN pair number |
| tr_asid | input | ASID_W | Translate request address-space tag |
| tr_odd | input | 1 | Selects the odd page of the pair |
| tr_hit | output | 1 | Translate hit, registered |
| tr_idx | output | IDX_W | Index of the matching entry |
| tr_pfn | output | PFN_W | Frame number of the selected page |
| tr_cattr | output | 3 | Cache attribute of the selected page |
| tr_dirty | output | 1 | Dirty flag of the selected page |
| tr_valid | output | 1 | Valid flag of the selected page |
| tr_global | output | 1 | Global flag of the matching entry |
| pb_vpn | input | VPN_W | Probe request VPN |
| pb_asid | input | ASID_W | Probe request tag |
| pb_idx | output | IDX_W+1 | Probe result index, all ones on miss |
| wr_en | input | 1 | Indexed write strobe |
| wr_idx | input | IDX_W+1 | Target entry index, may be out of range |
| wr_hi | input | VPN_W+ASID_W | {VPN, tag} for the entry |
| wr_mask | input | VPN_W | Page mask, 1 removes a VPN bit from the compare |
| wr_lo0 | input | PFN_W+6 | Even page low word |
| wr_lo1 | input | PFN_W+6 | Odd page low word |
| flush | input | 1 | Empties every entry |

## Verification
A write and a search can land in the same cycle. The bench writes a new entry and asks both ports for that entry's VPN in the same cycle. It expects a miss, because the search must see the array as it was before the write, and it expects a hit from the next request. A flush and a write can also coincide. The bench raises both together and then expects the written VPN to miss.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;

  // low word bit positions (fixed layout, decoded by the write port)
  localparam int LO_G   = 0;
  localparam int LO_V   = 1;
  localparam int LO_D   = 2;
  localparam int LO_C   = 3;
  localparam int LO_PFN = 6;
  localparam int CATTR_W = 3;
  localparam int NPORT = 2;   // translate + probe

  typedef logic [CATTR_W-1:0] cattr_t;

  typedef struct packed {
    cattr_t c;
    logic   d;
    logic   v;
  } pflags_t;

endpackage

// File: rtl/tlbp_entry.sv
module tlbp_entry
  import tlbp_pkg::*;
#(
  parameter int VPN_W  = 19,
  parameter int PFN_W  = 20,
  parameter int ASID_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              we,
  input  logic [VPN_W-1:0]  w_vpn,
  input  logic [VPN_W-1:0]  w_mask,
  input  logic [ASID_W-1:0] w_asid,
  input  logic [PFN_W-1:0]  w_pfn0,
  input  logic [PFN_W-1:0]  w_pfn1,
  input  pflags_t           w_f0,
  input  pflags_t           w_f1,
  input  logic              w_g,
  input  logic [VPN_W-1:0]  q_vpn  [NPORT],
  input  logic [ASID_W-1:0] q_asid [NPORT],
  output logic [NPORT-1:0]  q_hit,
  output logic [PFN_W-1:0]  e_pfn0,
  output logic [PFN_W-1:0]  e_pfn1,
  output pflags_t           e_f0,
  output pflags_t           e_f1,
  output logic              e_g
);

  logic              live_q;
  logic [VPN_W-1:0]  vpn_q;
  logic [VPN_W-1:0]  mask_q;
  logic [ASID_W-1:0] asid_q;

  // presence flag: the only state that needs a reset
  always_ff @(posedge clk) begin
    if (rst || flush) live_q <= 1'b0;
    else if (we)      live_q <= 1'b1;
  end

  // payload: plain registers, no reset
  always_ff @(posedge clk) begin
    if (we && !flush) begin
      vpn_q  <= w_vpn;
      mask_q <= w_mask;
      asid_q <= w_asid;
      e_pfn0 <= w_pfn0;
      e_pfn1 <= w_pfn1;
      e_f0   <= w_f0;
      e_f1   <= w_f1;
      e_g    <= w_g;
    end
  end

  // one comparator per search port
  for (genvar p = 0; p < NPORT; p++) begin : g_cmp
    logic vpn_eq;
    logic tag_ok;
    assign vpn_eq   = ((q_vpn[p] ^ vpn_q) & ~mask_q) == '0;
    assign tag_ok   = e_g || (q_asid[p] == asid_q);
    assign q_hit[p] = live_q && vpn_eq && tag_ok;
  end

endmodule

// File: rtl/tlbp_pick.sv
module tlbp_pick #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // scan from the top so the lowest set bit is the last one kept
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any = |req;

endmodule

// File: rtl/tlbp_array.sv
module tlbp_array
  import tlbp_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 19,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int WIDX_W = IDX_W + 1,
  localparam int LO_W   = PFN_W + LO_PFN,
  localparam int HI_W   = VPN_W + ASID_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [VPN_W-1:0]  tr_vpn,
  input  logic [ASID_W-1:0] tr_asid,
  input  logic              tr_odd,
  output logic              tr_hit,
  output logic [IDX_W-1:0]  tr_idx,
  output logic [PFN_W-1:0]  tr_pfn,
  output logic [2:0]        tr_cattr,
  output logic              tr_dirty,
  output logic              tr_valid,
  output logic              tr_global,
  input  logic [VPN_W-1:0]  pb_vpn,
  input  logic [ASID_W-1:0] pb_asid,
  output logic [WIDX_W-1:0] pb_idx,
  input  logic              wr_en,
  input  logic [WIDX_W-1:0] wr_idx,
  input  logic [HI_W-1:0]   wr_hi,
  input  logic [VPN_W-1:0]  wr_mask,
  input  logic [LO_W-1:0]   wr_lo0,
  input  logic [LO_W-1:0]   wr_lo1,
  input  logic              flush
);

  localparam int PT = 0;   // translate port number
  localparam int PP = 1;   // probe port number

  // ---------------- write decode ----------------
  logic [VPN_W-1:0]  w_vpn;
  logic [ASID_W-1:0] w_asid;
  logic [PFN_W-1:0]  w_pfn0, w_pfn1;
  pflags_t           w_f0, w_f1;
  logic              w_g;
  logic              w_ok;
  logic [ENTRIES-1:0] we_vec;

  assign w_vpn  = wr_hi[HI_W-1:ASID_W];
  assign w_asid = wr_hi[ASID_W-1:0];
  assign w_pfn0 = wr_lo0[LO_W-1:LO_PFN];
  assign w_pfn1 = wr_lo1[LO_W-1:LO_PFN];
  assign w_f0   = '{c: wr_lo0[LO_C+CATTR_W-1:LO_C], d: wr_lo0[LO_D], v: wr_lo0[LO_V]};
  assign w_f1   = '{c: wr_lo1[LO_C+CATTR_W-1:LO_C], d: wr_lo1[LO_D], v: wr_lo1[LO_V]};
  assign w_g    = wr_lo0[LO_G] & wr_lo1[LO_G];
  assign w_ok   = wr_en && !flush;

  // ---------------- entry array ----------------
  logic [VPN_W-1:0]  q_vpn  [NPORT];
  logic [ASID_W-1:0] q_asid [NPORT];

  assign q_vpn[PT]  = tr_vpn;
  assign q_asid[PT] = tr_asid;
  assign q_vpn[PP]  = pb_vpn;
  assign q_asid[PP] = pb_asid;

  logic [NPORT-1:0]   e_hit  [ENTRIES];
  logic [PFN_W-1:0]   e_pfn0 [ENTRIES];
  logic [PFN_W-1:0]   e_pfn1 [ENTRIES];
  pflags_t            e_f0   [ENTRIES];
  pflags_t            e_f1   [ENTRIES];
  logic               e_g    [ENTRIES];
  logic [ENTRIES-1:0] m_vec  [NPORT];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    assign we_vec[i] = w_ok && (wr_idx == WIDX_W'(i));

    tlbp_entry #(
      .VPN_W (VPN_W),
      .PFN_W (PFN_W),
      .ASID_W(ASID_W)
    ) u_ent (
      .clk   (clk),
      .rst   (rst),
      .flush (flush),
      .we    (we_vec[i]),
      .w_vpn (w_vpn),
      .w_mask(wr_mask),
      .w_asid(w_asid),
      .w_pfn0(w_pfn0),
      .w_pfn1(w_pfn1),
      .w_f0  (w_f0),
      .w_f1  (w_f1),
      .w_g   (w_g),
      .q_vpn (q_vpn),
      .q_asid(q_asid),
      .q_hit (e_hit[i]),
      .e_pfn0(e_pfn0[i]),
      .e_pfn1(e_pfn1[i]),
      .e_f0  (e_f0[i]),
      .e_f1  (e_f1[i]),
      .e_g   (e_g[i])
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_col
      assign m_vec[p][i] = e_hit[i][p];
    end
  end

  // ---------------- priority pick per port ----------------
  logic [NPORT-1:0] any;
  logic [IDX_W-1:0] sel [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_pick
    tlbp_pick #(
      .N    (ENTRIES),
      .IDX_W(IDX_W)
    ) u_pick (
      .req(m_vec[p]),
      .any(any[p]),
      .idx(sel[p])
    );
  end

  // ---------------- translate result mux ----------------
  logic [PFN_W-1:0] t_pfn;
  pflags_t          t_f;
  logic             t_g;

  always_comb begin
    t_pfn = '0;
    t_f   = '0;
    t_g   = 1'b0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (any[PT] && sel[PT] == IDX_W'(i)) begin
        t_pfn = tr_odd ? e_pfn1[i] : e_pfn0[i];
        t_f   = tr_odd ? e_f1[i]   : e_f0[i];
        t_g   = e_g[i];
      end
    end
  end

  // ---------------- output registers ----------------
  always_ff @(posedge clk) begin
    if (rst) begin
      tr_hit    <= 1'b0;
      tr_idx    <= '0;
      tr_pfn    <= '0;
      tr_cattr  <= '0;
      tr_dirty  <= 1'b0;
      tr_valid  <= 1'b0;
      tr_global <= 1'b0;
      pb_idx    <= '1;
    end else begin
      tr_hit    <= any[PT];
      tr_idx    <= any[PT] ? sel[PT] : '0;
      tr_pfn    <= t_pfn;
      tr_cattr  <= t_f.c;
      tr_dirty  <= t_f.d;
      tr_valid  <= t_f.v;
      tr_global <= t_g;
      pb_idx    <= any[PP] ? {1'b0, sel[PP]} : '1;
    end
  end

endmodule

// File: rtl/tlbp_chk.sv
module tlbp_chk #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 19,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = 4,
  parameter int WIDX_W  = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              flush,
  input logic              wr_en,
  input logic [VPN_W-1:0]  tr_vpn,
  input logic [ASID_W-1:0] tr_asid,
  input logic [VPN_W-1:0]  pb_vpn,
  input logic [ASID_W-1:0] pb_asid,
  input logic              tr_hit,
  input logic [IDX_W-1:0]  tr_idx,
  input logic [PFN_W-1:0]  tr_pfn,
  input logic              tr_valid,
  input logic [WIDX_W-1:0] pb_idx
);

  localparam logic [WIDX_W-1:0] NONE = '1;
  localparam logic [WIDX_W-1:0] LIM  = WIDX_W'(ENTRIES);

  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !tr_hit && pb_idx == NONE);                                   // R1

  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (rst)
    $past(flush, 2) && !$past(wr_en) && !$past(rst, 2) |-> !tr_hit && pb_idx == NONE); // R1

  AST_PROBE_RANGE: assert property (@(posedge clk) disable iff (rst)
    pb_idx == NONE || pb_idx < LIM);                                              // R5

  AST_PORTS_AGREE: assert property (@(posedge clk) disable iff (rst)
    $past(tr_vpn == pb_vpn && tr_asid == pb_asid) |->
      (tr_hit == (pb_idx != NONE)) && (!tr_hit || pb_idx == {1'b0, tr_idx}));     // R6

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !tr_hit |-> tr_idx == '0 && tr_pfn == '0 && !tr_valid);                        // R10

endmodule

bind tlbp_array tlbp_chk #(
  .ENTRIES(ENTRIES),
  .VPN_W  (VPN_W),
  .PFN_W  (PFN_W),
  .ASID_W (ASID_W),
  .IDX_W  (IDX_W),
  .WIDX_W (WIDX_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .flush   (flush),
  .wr_en   (wr_en),
  .tr_vpn  (tr_vpn),
  .tr_asid (tr_asid),
  .pb_vpn  (pb_vpn),
  .pb_asid (pb_asid),
  .tr_hit  (tr_hit),
  .tr_idx  (tr_idx),
  .tr_pfn  (tr_pfn),
  .tr_valid(tr_valid),
  .pb_idx  (pb_idx)
);

// File: tb/tb_tlbp_array.sv
module tb_tlbp_array;

  localparam int ENTRIES = 16;
  localparam int VPN_W   = 19;
  localparam int PFN_W   = 20;
  localparam int ASID_W  = 8;
  localparam int IDX_W   = 4;
  localparam int WIDX_W  = 5;
  localparam int LO_W    = PFN_W + 6;
  localparam logic [WIDX_W-1:0] NONE = '1;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [VPN_W-1:0]  tr_vpn = '0;
  logic [ASID_W-1:0] tr_asid = '0;
  logic              tr_odd = 1'b0;
  logic              tr_hit;
  logic [IDX_W-1:0]  tr_idx;
  logic [PFN_W-1:0]  tr_pfn;
  logic [2:0]        tr_cattr;
  logic              tr_dirty, tr_valid, tr_global;
  logic [VPN_W-1:0]  pb_vpn = '0;
  logic [ASID_W-1:0] pb_asid = '0;
  logic [WIDX_W-1:0] pb_idx;
  logic              wr_en = 1'b0;
  logic [WIDX_W-1:0] wr_idx = '0;
  logic [VPN_W+ASID_W-1:0] wr_hi = '0;
  logic [VPN_W-1:0]  wr_mask = '0;
  logic [LO_W-1:0]   wr_lo0 = '0, wr_lo1 = '0;
  logic              flush = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  tlbp_array #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W), .ASID_W(ASID_W)
  ) dut (
    .clk(clk), .rst(rst),
    .tr_vpn(tr_vpn), .tr_asid(tr_asid), .tr_odd(tr_odd),
    .tr_hit(tr_hit), .tr_idx(tr_idx), .tr_pfn(tr_pfn), .tr_cattr(tr_cattr),
    .tr_dirty(tr_dirty), .tr_valid(tr_valid), .tr_global(tr_global),
    .pb_vpn(pb_vpn), .pb_asid(pb_asid), .pb_idx(pb_idx),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_hi(wr_hi), .wr_mask(wr_mask),
    .wr_lo0(wr_lo0), .wr_lo1(wr_lo1), .flush(flush)
  );

  function automatic logic [LO_W-1:0] lo(input logic [PFN_W-1:0] pfn, input logic [2:0] c,
                                         input logic d, input logic v, input logic g);
    return {pfn, c, d, v, g};
  endfunction

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic set_wr(input int idx, input int vpn, input int asid, input int mask,
                        input logic [LO_W-1:0] l0, input logic [LO_W-1:0] l1);
    wr_en   = 1'b1;
    wr_idx  = WIDX_W'(idx);
    wr_hi   = {VPN_W'(vpn), ASID_W'(asid)};
    wr_mask = VPN_W'(mask);
    wr_lo0  = l0;
    wr_lo1  = l1;
  endtask

  task automatic write(input int idx, input int vpn, input int asid, input int mask,
                       input logic [LO_W-1:0] l0, input logic [LO_W-1:0] l1);
    @(negedge clk);
    set_wr(idx, vpn, asid, mask, l0, l1);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // request on both ports, result read one cycle later
  task automatic look(input int vpn, input int asid, input logic odd);
    @(negedge clk);
    tr_vpn = VPN_W'(vpn); tr_asid = ASID_W'(asid); tr_odd = odd;
    pb_vpn = VPN_W'(vpn); pb_asid = ASID_W'(asid);
    @(negedge clk);
  endtask

  task automatic expect_hit(input string req, input int idx);
    chk(req, "tr_hit", tr_hit, 1);
    chk(req, "tr_idx", tr_idx, idx);
    chk(req, "pb_idx", pb_idx, idx);
  endtask

  task automatic expect_miss(input string req);
    chk(req, "tr_hit", tr_hit, 0);
    chk(req, "pb_idx", pb_idx, NONE);
  endtask

  task automatic t_reset();
    look(0, 0, 1'b0);
    expect_miss("R1");
    chk("R10", "tr_idx", tr_idx, 0);
    chk("R10", "tr_pfn", tr_pfn, 0);
    chk("R10", "tr_cattr", tr_cattr, 0);
    chk("R10", "flags", {tr_dirty, tr_valid, tr_global}, 0);
  endtask

  task automatic t_fields();
    write(3, 'h123, 5, 0, lo('hAAAAA, 3'd3, 1, 1, 0), lo('h0BBBB, 3'd2, 0, 1, 0));
    look('h123, 5, 1'b0);
    expect_hit("R4", 3);
    chk("R4", "even pfn", tr_pfn, 'hAAAAA);
    chk("R4", "even cattr", tr_cattr, 3);
    chk("R4", "even d/v/g", {tr_dirty, tr_valid, tr_global}, 3'b110);
    look('h123, 5, 1'b1);
    chk("R4", "odd pfn", tr_pfn, 'h0BBBB);
    chk("R4", "odd cattr", tr_cattr, 2);
    chk("R4", "odd d/v/g", {tr_dirty, tr_valid, tr_global}, 3'b010);
    chk("R5", "probe hit", pb_idx, 3);
  endtask

  task automatic t_asid();
    look('h123, 6, 1'b0);
    expect_miss("R3");
    write(4, 'h200, 9, 0, lo(1, 0, 0, 1, 1), lo(2, 0, 0, 1, 1));
    look('h200, 1, 1'b0);
    expect_hit("R3", 4);
    chk("R3", "tr_global", tr_global, 1);
    write(5, 'h300, 9, 0, lo(1, 0, 0, 1, 1), lo(2, 0, 0, 1, 0));
    look('h300, 1, 1'b0);
    expect_miss("R3");
    look('h300, 9, 1'b0);
    expect_hit("R3", 5);
    chk("R3", "half global", tr_global, 0);
  endtask

  task automatic t_mask();
    write(6, 'h1000, 2, 'h0F, lo(7, 0, 0, 1, 0), lo(8, 0, 0, 1, 0));
    look('h100F, 2, 1'b0);
    expect_hit("R2", 6);
    look('h1010, 2, 1'b0);
    expect_miss("R2");
  endtask

  task automatic t_prio();
    write(8, 'h400, 1, 0, lo('h88, 0, 0, 1, 0), lo(0, 0, 0, 0, 0));
    write(2, 'h400, 1, 0, lo('h22, 0, 0, 1, 0), lo(0, 0, 0, 0, 0));
    look('h400, 1, 1'b0);
    expect_hit("R6", 2);
    chk("R6", "tr_pfn", tr_pfn, 'h22);
  endtask

  task automatic t_range();
    write(16, 'h500, 1, 0, lo(5, 0, 0, 1, 0), lo(5, 0, 0, 1, 0));
    look('h500, 1, 1'b0);
    expect_miss("R7");
    look('h123, 5, 1'b0);
    expect_hit("R7", 3);
  endtask

  task automatic t_replace();
    write(3, 'h777, 5, 0, lo('h77, 0, 0, 1, 0), lo(0, 0, 0, 0, 0));
    look('h123, 5, 1'b0);
    expect_miss("R8");
    look('h777, 5, 1'b0);
    expect_hit("R8", 3);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    set_wr(9, 'h888, 3, 0, lo('h99, 0, 0, 1, 0), lo(0, 0, 0, 0, 0));
    tr_vpn = VPN_W'('h888); tr_asid = 8'd3; tr_odd = 1'b0;
    pb_vpn = VPN_W'('h888); pb_asid = 8'd3;
    @(negedge clk);
    wr_en = 1'b0;
    expect_miss("R9");
    @(negedge clk);
    expect_hit("R9", 9);
  endtask

  task automatic t_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    look('h777, 5, 1'b0);
    expect_miss("R1");
    look('h200, 9, 1'b0);
    expect_miss("R1");
    @(negedge clk);
    flush = 1'b1;
    set_wr(1, 'h999, 4, 0, lo(1, 0, 0, 1, 0), lo(1, 0, 0, 1, 0));
    @(negedge clk);
    flush = 1'b0;
    wr_en = 1'b0;
    look('h999, 4, 1'b0);
    expect_miss("R1");
    chk("R10", "tr_idx", tr_idx, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_fields();
    t_asid();
    t_mask();
    t_prio();
    t_range();
    t_replace();
    t_same_cycle();
    t_flush();
    finish_run();
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

endmodule